// File: doc/BRIEF.md
# Phase-Staggered Bridge Channel Sequencer

This block turns three 1-bit density-modulated servo codes into switch enables for three H-bridges. The three channels are a sledge motor, a focus actuator and a radial actuator. A single master clock and a free-running four-phase counter set all timing. Each channel captures its input bit on its own rising edge of the four-edge cycle. Its bridge then switches on the falling edge that directly follows, half a cycle later. Input sampling and output switching therefore never share an edge. No two bridges ever switch on the same edge, which keeps supply and ground disturbance from lining up.

Each bridge has two high-side enables (`hs_a`, `hs_b`) and two low-side enables (`ls_c`, `ls_d`). A code of 1 closes the path A to D, and a code of 0 closes the path B to C. In every drive state exactly two switches conduct in series with the load. An idle input replaces the data with a self-alternating code, which gives zero average drive.

The data inputs are level-sampled bits and have no valid/ready handshake. They are always accepted, no back-pressure exists, and a value present between a channel's slots is never seen.

Top module: `bridge_phase_seq`

## Requirements
- R1: The phase counter is cleared by reset. Counting the rising edges after reset release from 0, edge k is slot k mod 4. Slot 0 samples `din[0]`, slot 1 samples `din[1]` and slot 2 samples `din[2]`. Slot 3 samples nothing.
- R2: A channel's captured bit appears on its bridge outputs at the falling edge that directly follows its sampling rising edge. The outputs then hold for four clocks, and input values present outside that channel's slot have no effect.
- R3: No switch enable ever changes in response to a rising clock edge.
- R4: At most one bridge changes its outputs on any falling edge, and the falling edge after slot 3 changes none.
- R5: Encoding, with bit order {a,b,c,d}: a code of 1 drives 1001 (`hs_a`, `ls_d`), and a code of 0 drives 0110 (`hs_b`, `ls_c`).
- R6: Once a bridge has been updated after reset, exactly two of its enables are high. A is never high together with C, B never with D, and A never with B.
- R7: Reset is synchronous. After a falling edge with `rst` high, every enable is 0, and the phase and stored codes are 0.
- R8: With `idle_en` high at a channel's sampling edge, the channel stores the inverse of its previous code and ignores `din`. The drive therefore alternates with a period of eight clocks.
- R9: A reset applied partway through a cycle clears the outputs, and the first rising edge after release is slot 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; inputs are sampled on rising edges and outputs switch on falling edges |
| rst | input | 1 | Synchronous reset, active high, sampled on both edges |
| idle_en | input | 1 | Replace the data with the alternating zero-average code |
| din | input | NCH | Density-modulated code per channel (0 sledge, 1 focus, 2 radial) |
| hs_a | output | NCH | High-side switch A enable per bridge |
| hs_b | output | NCH | High-side switch B enable per bridge |
| ls_c | output | NCH | Low-side switch C enable per bridge |
| ls_d | output | NCH | Low-side switch D enable per bridge |

## Verification
The assertions rely on two conditions. First, `rst` and all data inputs are steady across both clock edges, because reset is read by the rising-edge and the falling-edge registers alike. Second, reset is held for at least one full clock before the first check. The stimulus meets both conditions by changing every input one nanosecond after a falling edge, and by holding reset for two whole clocks. It also changes `din` before each individual slot, so that each channel is driven by a value that differs from the values presented to its neighbours.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  // Switch enables of one H-bridge: a,b high side; c,d low side.
  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } bridge_sw_t;

  localparam bridge_sw_t SW_OFF = '0;

  // Code 1 closes the A-D path, code 0 closes the B-C path.
  function automatic bridge_sw_t enc_code(input logic code);
    bridge_sw_t s;
    s.a = code;
    s.b = !code;
    s.c = !code;
    s.d = code;
    return s;
  endfunction

endpackage

// File: rtl/bsq_phase_gen.sv
module bsq_phase_gen #(
  parameter int unsigned NCH  = 3,
  parameter int unsigned PH_W = 2
) (
  input  logic           clk,
  input  logic           rst,
  output logic [NCH-1:0] smp_stb,
  output logic [NCH-1:0] upd_stb
);
  localparam int unsigned NPH = 1 << PH_W;

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  // Sampling slot n is phase n; the falling edge after it sees phase n+1.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_stb
    localparam int unsigned UPD_PH = (ch + 1) % NPH;
    assign smp_stb[ch] = (phase == PH_W'(ch));
    assign upd_stb[ch] = (phase == PH_W'(UPD_PH));
  end

  // R1: the phase advances by exactly one per rising edge after reset
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase == PH_W'($past(phase) + 1'b1));

endmodule

// File: rtl/bsq_sampler.sv
module bsq_sampler #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           idle_en,
  input  logic [NCH-1:0] smp_stb,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] code
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)              code[ch] <= 1'b0;
      else if (smp_stb[ch]) code[ch] <= idle_en ? !code[ch] : din[ch];
    end

    // R2: a stored code only moves in its own slot
    a_r2_hold_between_slots: assert property (@(posedge clk) disable iff (rst)
      !smp_stb[ch] |=> $stable(code[ch]));

    // R8: idle sampling inverts the previous code
    a_r8_idle_alternates: assert property (@(posedge clk) disable iff (rst)
      (smp_stb[ch] && idle_en) |=> code[ch] != $past(code[ch]));
  end

endmodule

// File: rtl/bsq_bridge_drv.sv
module bsq_bridge_drv
  import bsq_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] upd_stb,
  input  logic [NCH-1:0] code,
  output logic [NCH-1:0] hs_a,
  output logic [NCH-1:0] hs_b,
  output logic [NCH-1:0] ls_c,
  output logic [NCH-1:0] ls_d
);

  bridge_sw_t sw_q [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_br
    always_ff @(negedge clk) begin
      if (rst)              sw_q[ch] <= SW_OFF;
      else if (upd_stb[ch]) sw_q[ch] <= enc_code(code[ch]);
    end
    assign hs_a[ch] = sw_q[ch].a;
    assign hs_b[ch] = sw_q[ch].b;
    assign ls_c[ch] = sw_q[ch].c;
    assign ls_d[ch] = sw_q[ch].d;
  end

  // ---- checking logic: edge snapshots of the enables ----
  bridge_sw_t pos_snap [NCH];
  bridge_sw_t neg_snap [NCH];
  logic       pos_vld, neg_vld;
  logic [NCH-1:0] neg_chg;

  always_ff @(posedge clk) begin
    if (rst) pos_vld <= 1'b0;
    else     pos_vld <= 1'b1;
  end

  always_ff @(negedge clk) begin
    if (rst) neg_vld <= 1'b0;
    else     neg_vld <= 1'b1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    always_ff @(posedge clk) pos_snap[ch] <= sw_q[ch];
    always_ff @(negedge clk) neg_snap[ch] <= sw_q[ch];
    assign neg_chg[ch] = (sw_q[ch] != neg_snap[ch]);

    // R6: two series switches, never a same-side short
    a_r6_legal_pair: assert property (@(posedge clk) disable iff (rst)
      (sw_q[ch] == SW_OFF) ||
      ($countones(sw_q[ch]) == 2 && !(sw_q[ch].a && sw_q[ch].c) &&
       !(sw_q[ch].b && sw_q[ch].d) && !(sw_q[ch].a && sw_q[ch].b)));

    // R3: what held before a rising edge still holds before the next falling edge
    a_r3_rise_quiet: assert property (@(negedge clk) disable iff (rst)
      pos_vld |-> sw_q[ch] == pos_snap[ch]);
  end

  // R4: the last falling edge moved at most one bridge
  a_r4_single_bridge: assert property (@(posedge clk) disable iff (rst)
    neg_vld |-> $countones(neg_chg) <= 1);

endmodule

// File: rtl/bridge_phase_seq.sv
module bridge_phase_seq #(
  parameter int unsigned NCH  = 3,
  parameter int unsigned PH_W = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           idle_en,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] hs_a,
  output logic [NCH-1:0] hs_b,
  output logic [NCH-1:0] ls_c,
  output logic [NCH-1:0] ls_d
);

  logic [NCH-1:0] smp_stb;
  logic [NCH-1:0] upd_stb;
  logic [NCH-1:0] code;

  bsq_phase_gen #(.NCH(NCH), .PH_W(PH_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .smp_stb (smp_stb),
    .upd_stb (upd_stb)
  );

  bsq_sampler #(.NCH(NCH)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .idle_en (idle_en),
    .smp_stb (smp_stb),
    .din     (din),
    .code    (code)
  );

  bsq_bridge_drv #(.NCH(NCH)) u_drv (
    .clk     (clk),
    .rst     (rst),
    .upd_stb (upd_stb),
    .code    (code),
    .hs_a    (hs_a),
    .hs_b    (hs_b),
    .ls_c    (ls_c),
    .ls_d    (ls_d)
  );

endmodule

// File: tb/test_bridge_phase_seq.sv
module test_bridge_phase_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idle_en = 1'b0;
  logic [2:0] din = '0;
  logic [2:0] hs_a, hs_b, ls_c, ls_d;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_code = '0;
  logic [2:0] live = '0;

  always #5 clk = ~clk;

  bridge_phase_seq i_bridge_phase_seq (
    .clk(clk), .rst(rst), .idle_en(idle_en), .din(din),
    .hs_a(hs_a), .hs_b(hs_b), .ls_c(ls_c), .ls_d(ls_d)
  );

  function automatic logic [3:0] sw_of(input int ch);
    return {hs_a[ch], hs_b[ch], ls_c[ch], ls_d[ch]};
  endfunction

  function automatic logic [3:0] enc(input logic c);
    return c ? 4'b1001 : 4'b0110;
  endfunction

  task automatic check4(input string req, input int ch, input logic [3:0] exp);
    n_cmp++;
    if (sw_of(ch) !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d got %b expected %b", req, ch, sw_of(ch), exp);
    end
  endtask

  task automatic expect_all(input string req);
    for (int ch = 0; ch < 3; ch++)
      check4(req, ch, live[ch] ? enc(exp_code[ch]) : 4'b0000);
  endtask

  // R3: any enable change while clk is high came from a rising edge
  always @(hs_a or hs_b or ls_c or ls_d) begin
    if (!rst && clk === 1'b1) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R3 output moved on rising edge got %b%b%b%b expected no change",
               hs_a, hs_b, ls_c, ls_d);
    end
  end

  // One four-slot cycle; ds[s] is on din before slot s. Checks after every falling edge.
  task automatic run_frame(input logic [2:0] d0, input logic [2:0] d1,
                           input logic [2:0] d2, input logic [2:0] d3, input string req);
    logic [2:0] ds [4];
    ds[0] = d0; ds[1] = d1; ds[2] = d2; ds[3] = d3;
    for (int s = 0; s < 4; s++) begin
      din = ds[s];
      @(negedge clk); #1;
      if (s < 3) begin
        exp_code[s] = idle_en ? !exp_code[s] : ds[s][s];
        live[s] = 1'b1;
      end
      expect_all(req);
    end
  endtask

  // R7: synchronous reset clears every enable
  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    exp_code = '0; live = '0;
    expect_all("R7");
    rst = 1'b0;
  endtask

  // R5: encoding for constant inputs; R1: slot order with a mixed pattern
  task automatic t_const;
    run_frame(3'b111, 3'b111, 3'b111, 3'b111, "R5");
    run_frame(3'b000, 3'b000, 3'b000, 3'b000, "R5");
    run_frame(3'b101, 3'b101, 3'b101, 3'b010, "R1");
  endtask

  // R6: two legal series switches per bridge
  task automatic t_pairs;
    for (int ch = 0; ch < 3; ch++) begin
      logic [3:0] s;
      s = sw_of(ch);
      n_cmp++;
      if ($countones(s) != 2 || (s[3] && s[1]) || (s[2] && s[0]) || (s[3] && s[2])) begin
        n_bad++;
        $display("FAIL R6 ch%0d got %b expected a legal pair", ch, s);
      end
    end
  endtask

  // R2: din changes between slots; each channel sees only its own slot
  task automatic t_stagger;
    run_frame(3'b111, 3'b111, 3'b111, 3'b111, "R2");
    run_frame(3'b000, 3'b111, 3'b000, 3'b111, "R2");
    run_frame(3'b110, 3'b001, 3'b011, 3'b000, "R2");
  endtask

  // R4: random per-slot data; only the slot's bridge may move
  task automatic t_random;
    for (int f = 0; f < 24; f++)
      run_frame(3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), "R4");
  endtask

  // R8: idle pattern ignores din and alternates
  task automatic t_idle;
    idle_en = 1'b1;
    run_frame(3'b111, 3'b111, 3'b111, 3'b111, "R8");
    run_frame(3'b000, 3'b000, 3'b000, 3'b000, "R8");
    run_frame(3'b101, 3'b010, 3'b111, 3'b000, "R8");
    idle_en = 1'b0;
    run_frame(3'b011, 3'b011, 3'b011, 3'b011, "R8");
  endtask

  // R9: reset partway through a cycle restarts at slot 0
  task automatic t_midreset;
    din = 3'b110;
    @(negedge clk); #1;
    exp_code[0] = 1'b0; live[0] = 1'b1;
    expect_all("R9");
    rst = 1'b1;
    @(negedge clk); #1;
    exp_code = '0; live = '0;
    expect_all("R9");
    @(negedge clk); #1;
    rst = 1'b0;
    run_frame(3'b001, 3'b010, 3'b100, 3'b000, "R9");
    idle_en = 1'b1;
    run_frame(3'b000, 3'b000, 3'b000, 3'b000, "R9");
    idle_en = 1'b0;
  endtask

  initial begin
    @(negedge clk); #1;
    t_reset();
    t_const();
    t_pairs();
    t_stagger();
    t_random();
    t_idle();
    t_pairs();
    t_midreset();
    t_reset();
    run_frame(3'b010, 3'b010, 3'b010, 3'b010, "R7");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired got running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule